// File: doc/BRIEF.md
# Command SPI Slave with Clear-to-Send Handshake

This block is the host-facing serial port of a command-driven peripheral. A host selects it by pulling chip select low and shifts in an opcode byte followed by any number of argument bytes (SPI mode 0). When chip select returns high, an accepted opcode is handed to an internal executor. The executor is modelled here as a stub that stays busy for a programmable number of system clocks and then forms a response. The host polls a reply opcode. The first byte it gets back is a clear-to-send flag: 0x00 while the executor is still working and 0xFF once the response is ready. When the flag is 0xFF, the response bytes follow in the same transaction.

A second path returns four status bytes from the surrounding logic with no handshake. One of four opcodes picks the byte the burst starts from. Further bytes walk through the other three and wrap around. All four values are frozen when chip select falls, so a burst reads a single consistent snapshot.

Every pin is brought into the system clock domain through a synchronizer, and SCLK edges are detected there. The system clock therefore has to be much faster than SCLK.

Top module: `cmd_spi_slave`

## Requirements
- R1: Data in is sampled on SCLK rising edges, MSB first. Data out changes after SCLK falling edges, MSB first. The first output bit of a byte is present before that byte's first rising edge. The byte shifted out while the opcode is shifted in carries no defined value.
- R2: The first byte after chip select falls is the opcode. For a general opcode (any value other than 0x44, 0x50, 0x51, 0x53 and 0x57), the next PARAM_DEPTH bytes are kept as arguments 0 to PARAM_DEPTH-1 and any further bytes are dropped.
- R3: Opcode 0x44 reads the handshake. Output byte 1 is 0xFF if the executor was idle when the opcode byte completed, and 0x00 otherwise. When the flag was 0xFF, output bytes 2 to PARAM_DEPTH+1 are response bytes 0 to PARAM_DEPTH-1. All other output bytes are 0x00.
- R4: An accepted general opcode starts execution on the rising edge of chip select. The executor stays busy for exec_delay+1 system clocks. Response byte i is then argument i XOR the opcode, with an argument that was never sent counting as 0x00.
- R5: Opcodes 0x50, 0x51, 0x53 and 0x57 select start slot 0, 1, 2 and 3. Output byte k (k≥1) is slot (start+k-1) mod 4, where slot s is fast_status[8s+7:8s]. These reads are served even while the executor is busy.
- R6: The four status slots are captured when chip select falls. They hold for the whole transaction, even if fast_status changes during it.
- R7: A general opcode that arrives while the executor is busy is ignored: it neither restarts nor changes the pending response. It sets cmd_error, which stays set until the next general opcode is accepted.
- R8: While chip select is high, spi_miso_oe is 0. Raising chip select discards a partly received byte, so the next transaction starts on a byte boundary.
- R9: After reset, cmd_error and spi_miso_oe are 0, the handshake reads 0xFF and all response bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; low means high impedance |
| fast_status | input | 32 | Four status bytes, slot s at bits 8s+7..8s |
| exec_delay | input | DLY_W | Busy time of the executor stub, sampled at command start |
| cmd_error | output | 1 | Set when a general opcode is refused as busy |

## Verification
Some properties are checked on every cycle. The status snapshot changes only on a chip-select fall, the executor is never started while busy, a started execution stays busy until its counter expires, the error flag only rises while the executor is busy, the bit counter clears whenever select is high, and the output enable drops after select has been high for two clocks. Other behaviour can only be shown by the bench's transactions. These are the byte order of a wrapping status burst, the handshake flipping from 0x00 to 0xFF around the programmed delay, the XOR response formed from a short or overlong argument list, an ignored command leaving the earlier response intact, and the recovery after an aborted partial byte.

// File: rtl/cmdspi_pkg.sv
// Package: opcodes, transaction kinds and decode helpers shared by the
// command SPI slave. Assumes 8-bit bytes and exactly four status slots.
package cmdspi_pkg;
    localparam int         BYTE_W    = 8;
    localparam int         N_FAST    = 4;
    localparam logic [7:0] OP_REPLY  = 8'h44;
    localparam logic [7:0] OP_FAST_0 = 8'h50;
    localparam logic [7:0] OP_FAST_1 = 8'h51;
    localparam logic [7:0] OP_FAST_2 = 8'h53;
    localparam logic [7:0] OP_FAST_3 = 8'h57;

    typedef enum logic [1:0] {
        TXN_NONE  = 2'd0,
        TXN_FAST  = 2'd1,
        TXN_REPLY = 2'd2,
        TXN_CMD   = 2'd3
    } txn_kind_e;

    // True when the opcode selects a status burst
    function automatic logic is_fast(input logic [7:0] op);
        return (op == OP_FAST_0) || (op == OP_FAST_1) ||
               (op == OP_FAST_2) || (op == OP_FAST_3);
    endfunction

    // Start slot of a status burst for a given opcode
    function automatic logic [1:0] fast_slot(input logic [7:0] op);
        logic [1:0] s;
        case (op)
            OP_FAST_1: s = 2'd1;
            OP_FAST_2: s = 2'd2;
            OP_FAST_3: s = 2'd3;
            default:   s = 2'd0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/spi_sync_edge.sv
// Brings SCLK, chip select and data-in into the system clock domain
// through a STAGES-deep flop chain and produces single-cycle edge strobes.
// Assumes the system clock is many times faster than SCLK.
module spi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_a,
    input  logic cs_n_a,
    input  logic mosi_a,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_n_s,
    output logic mosi_s
);
    localparam int              NSIG     = 3;
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b010; // {mosi, cs_n, sclk}

    logic [NSIG-1:0] chain [STAGES];
    logic [NSIG-1:0] prev_q;
    logic [NSIG-1:0] cur;

    // Synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_LVL;
            prev_q <= IDLE_LVL;
        end else begin
            chain[0] <= {mosi_a, cs_n_a, sclk_a};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign cur       = chain[STAGES-1];
    assign sclk_rise = cur[0] & ~prev_q[0];
    assign sclk_fall = ~cur[0] & prev_q[0];
    assign cs_fall   = ~cur[1] & prev_q[1];
    assign cs_rise   = cur[1] & ~prev_q[1];
    assign cs_n_s    = cur[1];
    assign mosi_s    = cur[2];
endmodule

// File: rtl/spi_byte_shifter.sv
// Mode-0 byte shifter in the system clock domain: assembles received bytes
// on SCLK rising strobes and shifts out tx_byte on falling strobes, loading
// a new byte on the first fall after each received byte completes.
// Assumes tx_byte is settled a few cycles after rx_valid.
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         cs_n_s,
    input  logic         mosi_s,
    input  logic [W-1:0] tx_byte,
    output logic         rx_valid,
    output logic [W-1:0] rx_byte,
    output logic         miso
);
    localparam int CNT_W = $clog2(W);

    logic [CNT_W-1:0] bit_cnt_q;
    logic [W-1:0]     rx_sh_q;
    logic [W-1:0]     tx_sh_q;
    logic             load_pend_q;

    // Receive side: bit counter, shift register and byte strobe
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sclk_rise) begin
                rx_sh_q   <= {rx_sh_q[W-2:0], mosi_s};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (bit_cnt_q == CNT_W'(W-1)) rx_valid <= 1'b1;
            end
        end
    end

    // Transmit side: load on the fall after a byte boundary, else shift
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            tx_sh_q     <= '0;
            load_pend_q <= 1'b0;
        end else begin
            if (rx_valid) load_pend_q <= 1'b1;
            if (sclk_fall) begin
                if (load_pend_q) begin
                    tx_sh_q     <= tx_byte;
                    load_pend_q <= 1'b0;
                end else begin
                    tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
                end
            end
        end
    end

    assign rx_byte = rx_sh_q;
    assign miso    = tx_sh_q[W-1];

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt_q == '0) && !rx_valid); // R8
endmodule

// File: rtl/cmd_exec_stub.sv
// Stand-in for the command processor: on start it latches opcode and
// arguments, stays busy for delay+1 cycles, then writes response byte i as
// argument i XOR opcode. Assumes start is only raised while idle.
module cmd_exec_stub #(
    parameter int DEPTH = 4,
    parameter int DLY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         start_op,
    input  logic [DEPTH*8-1:0] start_prm,
    input  logic [DLY_W-1:0]   delay,
    output logic               busy,
    output logic [DEPTH*8-1:0] resp
);
    logic [DLY_W-1:0]   cnt_q;
    logic               busy_q;
    logic [7:0]         op_q;
    logic [DEPTH*8-1:0] prm_q;
    logic [DEPTH*8-1:0] resp_q;
    logic [DEPTH*8-1:0] resp_nx;
    logic               done;

    assign done = busy_q && (cnt_q == '0);

    // Busy flag and countdown of the programmed execution time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= delay;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Latch of the command being executed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            prm_q <= '0;
        end else if (start) begin
            op_q  <= start_op;
            prm_q <= start_prm;
        end
    end

    // Per-byte response formation
    for (genvar i = 0; i < DEPTH; i++) begin : g_resp
        assign resp_nx[i*8 +: 8] = prm_q[i*8 +: 8] ^ op_q;
    end

    // Response buffer, written when execution ends
    always_ff @(posedge clk) begin
        if (!rst_n)    resp_q <= '0;
        else if (done) resp_q <= resp_nx;
    end

    assign busy = busy_q;
    assign resp = resp_q;

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0 && !start) |=> busy_q); // R4
endmodule

// File: rtl/cmd_spi_slave.sv
// Command SPI slave top: decodes the opcode of each transaction, collects
// arguments, answers handshake polls, serves the four-slot status burst
// from a snapshot taken at select fall, and starts the executor stub at
// select rise. Assumes clk is at least ten times the SCLK rate.
module cmd_spi_slave #(
    parameter int PARAM_DEPTH = 4,
    parameter int DLY_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    input  logic [31:0]      fast_status,
    input  logic [DLY_W-1:0] exec_delay,
    output logic             cmd_error
);
    import cmdspi_pkg::*;

    localparam int IDX_W  = 8;
    localparam int PRM_W  = PARAM_DEPTH * BYTE_W;
    localparam int SNAP_W = N_FAST * BYTE_W;

    logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_n_s, mosi_s;
    logic rx_valid, miso_raw;
    logic [7:0] rx_byte;
    logic [7:0] tx_sel;

    txn_kind_e         kind_q;
    logic [IDX_W-1:0]  byte_idx_q;
    logic [1:0]        fast_start_q;
    logic              cts_ok_q;
    logic [7:0]        op_q;
    logic [PRM_W-1:0]  prm_q;
    logic [SNAP_W-1:0] snap_q;
    logic              err_q;
    logic              exec_start, exec_busy;
    logic [PRM_W-1:0]  exec_resp;
    logic [1:0]        slot;

    spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_a(spi_sclk), .cs_n_a(spi_cs_n), .mosi_a(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s)
    );

    spi_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s), .tx_byte(tx_sel),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(miso_raw)
    );

    cmd_exec_stub #(.DEPTH(PARAM_DEPTH), .DLY_W(DLY_W)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .start(exec_start), .start_op(op_q), .start_prm(prm_q),
        .delay(exec_delay), .busy(exec_busy), .resp(exec_resp)
    );

    assign exec_start = cs_rise && (kind_q == TXN_CMD);

    // Status snapshot, refreshed only when a transaction opens
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (cs_fall) snap_q <= fast_status;
    end

    // Opcode decode and byte position within the transaction
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            kind_q       <= TXN_NONE;
            byte_idx_q   <= '0;
            fast_start_q <= '0;
            cts_ok_q     <= 1'b0;
            if (!rst_n) op_q <= '0;
        end else if (rx_valid) begin
            byte_idx_q <= byte_idx_q + 1'b1;
            if (byte_idx_q == '0) begin
                if (is_fast(rx_byte)) begin
                    kind_q       <= TXN_FAST;
                    fast_start_q <= fast_slot(rx_byte);
                end else if (rx_byte == OP_REPLY) begin
                    kind_q   <= TXN_REPLY;
                    cts_ok_q <= !exec_busy;
                end else if (exec_busy) begin
                    kind_q <= TXN_NONE;
                end else begin
                    kind_q <= TXN_CMD;
                    op_q   <= rx_byte;
                end
            end
        end
    end

    // Argument capture; bytes beyond the buffer are dropped
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) begin
            prm_q <= '0;
        end else if (rx_valid && kind_q == TXN_CMD) begin
            for (int k = 0; k < PARAM_DEPTH; k++)
                if (byte_idx_q == IDX_W'(k + 1)) prm_q[k*8 +: 8] <= rx_byte;
        end
    end

    // Error flag: set on a refused opcode, cleared on the next accepted one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (exec_start) begin
            err_q <= 1'b0;
        end else if (!cs_n_s && rx_valid && byte_idx_q == '0 &&
                     !is_fast(rx_byte) && rx_byte != OP_REPLY && exec_busy) begin
            err_q <= 1'b1;
        end
    end

    assign slot = fast_start_q + byte_idx_q[1:0] - 2'd1;

    // Selection of the byte to shift out next
    always_comb begin
        tx_sel = '0;
        case (kind_q)
            TXN_FAST:  tx_sel = snap_q[{slot, 3'b000} +: 8];
            TXN_REPLY: begin
                if (byte_idx_q == IDX_W'(1)) begin
                    tx_sel = cts_ok_q ? 8'hFF : 8'h00;
                end else if (cts_ok_q) begin
                    for (int k = 0; k < PARAM_DEPTH; k++)
                        if (byte_idx_q == IDX_W'(k + 2)) tx_sel = exec_resp[k*8 +: 8];
                end
            end
            default:   tx_sel = '0;
        endcase
    end

    assign spi_miso    = cs_n_s ? 1'b0 : miso_raw;
    assign spi_miso_oe = !cs_n_s;
    assign cmd_error   = err_q;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(snap_q)); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(exec_busy)); // R7
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && byte_idx_q == '0 && !cs_n_s && exec_busy) |=> kind_q != TXN_CMD); // R7

    if (SYNC_STAGES == 2) begin : g_oe_chk
        AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe); // R8
    end
endmodule

// File: tb/cmd_spi_slave_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random commands
// and status bursts, checked against bench-side reference functions.
module cmd_spi_slave_tb_top;
    localparam int DEPTH = 4;
    localparam int H     = 10;   // system clocks per SCLK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe, cmd_error;
    logic [31:0] fast_status = 32'h0;
    logic [15:0] exec_delay  = 16'd0;

    int          n_chk = 0, n_fail = 0;
    logic [7:0]  tx_buf [16];
    logic [7:0]  rx_buf [16];
    logic [7:0]  m_resp [DEPTH];
    bit          mid_en = 1'b0;
    logic [31:0] mid_val = 32'h0;

    always #2.5 clk = ~clk;

    cmd_spi_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .fast_status(fast_status), .exec_delay(exec_delay),
        .cmd_error(cmd_error)
    );

    function automatic logic [7:0] exp_fast(input logic [31:0] v,
                                            input logic [7:0] op, input int k);
        int s;
        s = (op == 8'h51) ? 1 : (op == 8'h53) ? 2 : (op == 8'h57) ? 3 : 0;
        return v[((s + k - 1) % 4) * 8 +: 8];
    endfunction

    function automatic bit reserved(input logic [7:0] op);
        return op == 8'h44 || op == 8'h50 || op == 8'h51 || op == 8'h53 || op == 8'h57;
    endfunction

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full transaction of n bytes from tx_buf; received bytes go to rx_buf
    task automatic xfer(input int n);
        cs_n = 1'b0;
        wait_clk(H);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tx_buf[b][i];
                wait_clk(H);
                rx_buf[b][i] = miso;
                sclk = 1'b1;
                wait_clk(H);
                sclk = 1'b0;
            end
            if (b == 0 && mid_en) fast_status = mid_val;
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(20);
    endtask

    task automatic partial(input int bits);
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < bits; i++) begin
            mosi = 1'b1;
            wait_clk(H);
            sclk = 1'b1;
            wait_clk(H);
            sclk = 1'b0;
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(20);
    endtask

    task automatic send_cmd(input logic [7:0] op, input int np, input logic [15:0] dly);
        exec_delay = dly;
        tx_buf[0] = op;
        for (int i = 1; i <= np; i++) tx_buf[i] = 8'($urandom);
        for (int i = 0; i < DEPTH; i++)
            m_resp[i] = ((i < np) ? tx_buf[i+1] : 8'h00) ^ op;
        xfer(1 + np);
    endtask

    task automatic read_reply();
        tx_buf[0] = 8'h44;
        for (int i = 1; i < DEPTH + 3; i++) tx_buf[i] = 8'h00;
        xfer(DEPTH + 3);
    endtask

    task automatic poll_ready(output bit ok);
        ok = 1'b0;
        for (int p = 0; p < 12 && !ok; p++) begin
            read_reply();
            if (rx_buf[1] == 8'hFF) ok = 1'b1;
        end
    endtask

    task automatic check_reply(input string req);
        for (int i = 0; i < DEPTH; i++) chk8(req, rx_buf[2+i], m_resp[i]);
        chk8(req, rx_buf[DEPTH+2], 8'h00);
    endtask

    task automatic fast_read(input logic [7:0] op, input int n, input logic [31:0] v,
                             input string req);
        tx_buf[0] = op;
        for (int i = 1; i < n; i++) tx_buf[i] = 8'($urandom);
        xfer(n);
        for (int k = 1; k < n; k++) chk8(req, rx_buf[k], exp_fast(v, op, k));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ok;
        logic [7:0] op;
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R9: reset state
        chk8("R9 err", {7'b0, cmd_error}, 8'h00);
        chk8("R9 oe", {7'b0, miso_oe}, 8'h00);
        read_reply();
        chk8("R9 R3 cts", rx_buf[1], 8'hFF);
        for (int i = 0; i < DEPTH; i++) m_resp[i] = 8'h00;
        check_reply("R9 resp");

        // R8: output enable follows select
        cs_n = 1'b0; wait_clk(6);
        chk8("R8 oe low-sel", {7'b0, miso_oe}, 8'h01);
        cs_n = 1'b1; wait_clk(6);
        chk8("R8 oe high-sel", {7'b0, miso_oe}, 8'h00);

        // R4 R3: busy window around delay 600
        send_cmd(8'h12, 3, 16'd600);
        read_reply();
        chk8("R4 R3 busy cts", rx_buf[1], 8'h00);
        chk8("R3 busy body", rx_buf[2], 8'h00);
        wait_clk(650);
        read_reply();
        chk8("R4 R3 done cts", rx_buf[1], 8'hFF);
        check_reply("R4 R1 resp");

        // R7: command while busy is refused and flagged
        send_cmd(8'h21, 2, 16'd3000);
        begin
            logic [7:0] keep [DEPTH];
            for (int i = 0; i < DEPTH; i++) keep[i] = m_resp[i];
            send_cmd(8'h22, 4, 16'd5);
            chk8("R7 err set", {7'b0, cmd_error}, 8'h01);
            // R5: status burst served while busy
            v = 32'hA1B2C3D4;
            fast_status = v;
            fast_read(8'h53, 7, v, "R5 busy burst");
            for (int i = 0; i < DEPTH; i++) m_resp[i] = keep[i];
        end
        poll_ready(ok);
        chk8("R7 ready", {7'b0, ok}, 8'h01);
        check_reply("R7 kept resp");
        chk8("R7 err held", {7'b0, cmd_error}, 8'h01);
        send_cmd(8'h33, 0, 16'd0);
        chk8("R7 err clear", {7'b0, cmd_error}, 8'h00);
        poll_ready(ok);
        check_reply("R4 no args");

        // R2: surplus arguments dropped
        send_cmd(8'h40, 7, 16'd10);
        poll_ready(ok);
        check_reply("R2 overlong");

        // R6: snapshot held against a mid-transaction change
        fast_status = 32'h11223344;
        mid_en = 1'b1;
        mid_val = 32'h99887766;
        fast_read(8'h50, 6, 32'h11223344, "R6 snapshot");
        mid_en = 1'b0;
        fast_read(8'h57, 6, 32'h99887766, "R6 refresh");

        // R8: aborted partial byte then clean transaction
        partial(3);
        read_reply();
        chk8("R8 after abort", rx_buf[1], 8'hFF);
        check_reply("R8 resp intact");

        // Random commands and bursts
        for (int it = 0; it < 14; it++) begin
            do op = 8'($urandom); while (reserved(op));
            send_cmd(op, int'($urandom_range(0, 6)), 16'($urandom_range(20, 300)));
            poll_ready(ok);
            chk8("R4 rand ready", {7'b0, ok}, 8'h01);
            check_reply("R4 R2 rand");
            v = $urandom;
            fast_status = v;
            case ($urandom_range(0, 3))
                0: op = 8'h50;
                1: op = 8'h51;
                2: op = 8'h53;
                default: op = 8'h57;
            endcase
            fast_read(op, int'($urandom_range(2, 7)), v, "R5 R1 rand burst");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule